// File: doc/BRIEF.md
# USB Endpoint Buffer Descriptor Handshake Engine

This block is the device-side decision logic for one USB endpoint buffer descriptor. A CPU port loads a status byte and a 10-bit byte count while the core owns the descriptor. Setting the ownership flag hands the descriptor to the engine. From then on, CPU writes are locked out until the engine hands it back.

For each token the engine gets the token kind (IN, OUT or SETUP), the parity of the received data PID and the received length. One cycle later it reports exactly one handshake outcome: ACK, NAK, STALL or IGNORE.

On an ACK the engine does four things in that same cycle:
- returns ownership to the core;
- updates the expected data toggle;
- for OUT and SETUP, writes the received length back into the count;
- raises a one-cycle completion pulse.

A STALL or a toggle failure changes nothing in the descriptor, and the engine keeps ownership.

Top module: `usb_bd_engine`

## Requirements
- R1: After a synchronous active-high reset, the status byte reads 0x00, the low count byte reads 0x00, and `res_valid` and `xfer_done` are 0.
- R2: Status byte layout: bit 7 = engine owns, bit 6 = expected toggle (1 = DATA1), bit 3 = toggle check enable, bit 2 = stall enable, bits 1:0 = count bits 9:8. Bits 5:4 always read 0, whatever value is written to them.
- R3: While the core owns the descriptor (bit 7 = 0), CPU writes to the status byte and to the low count byte take effect on the next clock. A status write with bit 7 = 1 hands the descriptor to the engine.
- R4: While the engine owns the descriptor, CPU writes to the status byte and to the count are ignored.
- R5: Result encoding on `res_code`: 1 = ACK, 2 = NAK, 3 = STALL, 4 = IGNORE. The result appears with `res_valid` = 1 in the cycle after the token. Token kind encoding on `tok_kind`: 0 = OUT, 1 = IN, 2 = SETUP.
- R6: A token that arrives while the core owns the descriptor gives NAK, and the descriptor does not change.
- R7: A token that arrives while the engine owns the descriptor with stall enabled gives STALL. Ownership, the toggle and the count do not change.
- R8: With toggle checking enabled, an OUT whose data PID parity differs from the expected toggle gives IGNORE, and the descriptor does not change.
- R9: With toggle checking disabled, an OUT is accepted whatever its data PID parity.
- R10: A SETUP is accepted even when its parity does not match. Afterwards the expected toggle is DATA1.
- R11: An accepted IN reports the stored count on `res_len` and leaves the count unchanged. Counts run up to 1023.
- R12: An accepted OUT or SETUP stores the received length as the new count and reports it on `res_len`.
- R13: On ACK, the ownership bit reads 0 in the same cycle that `xfer_done` pulses high for exactly one cycle. A non-SETUP acceptance inverts the expected toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stat_we | input | 1 | CPU write strobe for the status byte |
| cpu_stat_wdata | input | 8 | CPU status byte write data |
| cpu_cnt_we | input | 1 | CPU write strobe for count bits 7:0 |
| cpu_cnt_wdata | input | 8 | CPU count low byte write data |
| stat_rd | output | 8 | Current status byte |
| cnt_lo_rd | output | 8 | Current count bits 7:0 |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_odd | input | 1 | Data PID parity (1 = DATA1) |
| tok_rx_len | input | 10 | Bytes received with OUT or SETUP |
| res_valid | output | 1 | Handshake outcome valid |
| res_code | output | 3 | Outcome: 1 ACK, 2 NAK, 3 STALL, 4 IGNORE |
| res_len | output | 10 | Bytes moved on ACK |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
Faults in the ownership flag surface on the next token. A descriptor stuck in the core gives NAK where ACK is expected. One stuck in the engine is seen when a CPU write fails to read back, or when `xfer_done` fires without the bit-7 clear. A corrupted toggle shows within one token: a correct OUT comes back as IGNORE, or the toggle reads back wrong on the status byte in the cycle the result appears. A wrong count or a wrong write-back path shows on `res_len` and on the count readback in that same cycle.

// File: rtl/usb_bd_pkg.sv
package usb_bd_pkg;

    localparam int CNT_W  = 10;
    localparam int LO_W   = 8;
    localparam int HI_W   = CNT_W - LO_W;
    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [2:0] {
        HS_NONE   = 3'd0,
        HS_ACK    = 3'd1,
        HS_NAK    = 3'd2,
        HS_STALL  = 3'd3,
        HS_IGNORE = 3'd4
    } hs_e;

    typedef struct packed {
        logic own;
        logic tgl;
        logic chk;
        logic stall;
    } bd_flags_t;

    function automatic logic [STAT_W-1:0] stat_pack(bd_flags_t f, logic [HI_W-1:0] hi);
        return {f.own, f.tgl, 2'b00, f.chk, f.stall, hi};
    endfunction

    function automatic bd_flags_t stat_unpack(logic [STAT_W-1:0] b);
        bd_flags_t f;
        f.own   = b[7];
        f.tgl   = b[6];
        f.chk   = b[3];
        f.stall = b[2];
        return f;
    endfunction

endpackage

// File: rtl/usb_bd_regs.sv
module usb_bd_regs
    import usb_bd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_stat_we,
    input  logic [STAT_W-1:0]    cpu_stat_wdata,
    input  logic                 cpu_cnt_we,
    input  logic [LO_W-1:0]      cpu_cnt_wdata,
    input  logic                 eng_upd,
    input  logic                 eng_tgl,
    input  logic [CNT_W-1:0]     eng_cnt,
    output bd_flags_t            flags,
    output logic [CNT_W-1:0]     cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            cnt   <= '0;
        end else if (eng_upd) begin
            flags.own <= 1'b0;
            flags.tgl <= eng_tgl;
            cnt       <= eng_cnt;
        end else if (!flags.own) begin
            if (cpu_stat_we) begin
                flags              <= stat_unpack(cpu_stat_wdata);
                cnt[CNT_W-1:LO_W]  <= cpu_stat_wdata[HI_W-1:0];
            end
            if (cpu_cnt_we)
                cnt[LO_W-1:0] <= cpu_cnt_wdata;
        end
    end

    // R4: engine-owned descriptor only changes through an engine update
    a_r4_cpu_locked: assert property (@(posedge clk) disable iff (rst)
        (flags.own && !eng_upd) |=> (flags == $past(flags) && cnt == $past(cnt)));

    // R13: engine update always hands ownership back
    a_r13_upd_release: assert property (@(posedge clk) disable iff (rst)
        eng_upd |=> !flags.own);

endmodule

// File: rtl/usb_bd_decide.sv
module usb_bd_decide
    import usb_bd_pkg::*;
(
    input  bd_flags_t            flags,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 tok_valid,
    input  logic [1:0]           tok_kind,
    input  logic                 tok_odd,
    input  logic [CNT_W-1:0]     tok_rx_len,
    output hs_e                  hs,
    output logic                 accept,
    output logic                 nxt_tgl,
    output logic [CNT_W-1:0]     nxt_cnt,
    output logic [CNT_W-1:0]     xfer_len
);

    tok_kind_e kind;
    assign kind = tok_kind_e'(tok_kind);

    always_comb begin
        hs       = HS_NONE;
        accept   = 1'b0;
        nxt_tgl  = flags.tgl;
        nxt_cnt  = cnt;
        xfer_len = '0;
        if (tok_valid) begin
            if (!flags.own) begin
                hs = HS_NAK;
            end else if (flags.stall) begin
                hs = HS_STALL;
            end else begin
                unique case (kind)
                    TK_SETUP: begin
                        accept   = 1'b1;
                        nxt_tgl  = 1'b1;
                        nxt_cnt  = tok_rx_len;
                        xfer_len = tok_rx_len;
                    end
                    TK_OUT: begin
                        if (flags.chk && (tok_odd != flags.tgl)) begin
                            hs = HS_IGNORE;
                        end else begin
                            accept   = 1'b1;
                            nxt_tgl  = ~flags.tgl;
                            nxt_cnt  = tok_rx_len;
                            xfer_len = tok_rx_len;
                        end
                    end
                    TK_IN: begin
                        accept   = 1'b1;
                        nxt_tgl  = ~flags.tgl;
                        xfer_len = cnt;
                    end
                    default: hs = HS_IGNORE;
                endcase
                if (accept)
                    hs = HS_ACK;
            end
        end
    end

    // R7: a stalled descriptor never accepts
    always_comb begin
        if (tok_valid && flags.own && flags.stall)
            a_r7_stall_blocks: assert (!accept);
    end

endmodule

// File: rtl/usb_bd_engine.sv
module usb_bd_engine
    import usb_bd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_stat_we,
    input  logic [STAT_W-1:0]    cpu_stat_wdata,
    input  logic                 cpu_cnt_we,
    input  logic [LO_W-1:0]      cpu_cnt_wdata,
    output logic [STAT_W-1:0]    stat_rd,
    output logic [LO_W-1:0]      cnt_lo_rd,
    input  logic                 tok_valid,
    input  logic [1:0]           tok_kind,
    input  logic                 tok_odd,
    input  logic [CNT_W-1:0]     tok_rx_len,
    output logic                 res_valid,
    output logic [2:0]           res_code,
    output logic [CNT_W-1:0]     res_len,
    output logic                 xfer_done
);

    bd_flags_t          flags;
    logic [CNT_W-1:0]   cnt;
    hs_e                hs;
    logic               accept;
    logic               nxt_tgl;
    logic [CNT_W-1:0]   nxt_cnt;
    logic [CNT_W-1:0]   xfer_len;

    usb_bd_regs u_regs (
        .clk            (clk),
        .rst            (rst),
        .cpu_stat_we    (cpu_stat_we),
        .cpu_stat_wdata (cpu_stat_wdata),
        .cpu_cnt_we     (cpu_cnt_we),
        .cpu_cnt_wdata  (cpu_cnt_wdata),
        .eng_upd        (accept),
        .eng_tgl        (nxt_tgl),
        .eng_cnt        (nxt_cnt),
        .flags          (flags),
        .cnt            (cnt)
    );

    usb_bd_decide u_decide (
        .flags      (flags),
        .cnt        (cnt),
        .tok_valid  (tok_valid),
        .tok_kind   (tok_kind),
        .tok_odd    (tok_odd),
        .tok_rx_len (tok_rx_len),
        .hs         (hs),
        .accept     (accept),
        .nxt_tgl    (nxt_tgl),
        .nxt_cnt    (nxt_cnt),
        .xfer_len   (xfer_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_code  <= HS_NONE;
            res_len   <= '0;
            xfer_done <= 1'b0;
        end else begin
            res_valid <= tok_valid;
            res_code  <= hs;
            res_len   <= xfer_len;
            xfer_done <= accept;
        end
    end

    assign stat_rd   = stat_pack(flags, cnt[CNT_W-1:LO_W]);
    assign cnt_lo_rd = cnt[LO_W-1:0];

    // R2: unused status bits stay clear after any CPU write
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        cpu_stat_we |=> stat_rd[5:4] == 2'b00);

    // R6: core-owned descriptor answers NAK
    a_r6_nak_core: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !stat_rd[7]) |=> (res_code == HS_NAK && !xfer_done));

    // R7: stall keeps ownership and count
    a_r7_stall_keep: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && stat_rd[7] && stat_rd[2]) |=>
            (res_code == HS_STALL && stat_rd[7] && $stable(stat_rd) && $stable(cnt_lo_rd)));

    // R13: completion pulse coincides with release and lasts one cycle
    a_r13_done_release: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (!stat_rd[7] && res_code == HS_ACK));
    a_r13_done_single: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);

    // R5: a result is reported exactly when a token was presented
    a_r5_res_follows_tok: assert property (@(posedge clk) disable iff (rst)
        tok_valid |=> (res_valid && res_code != HS_NONE));

endmodule

// File: tb/usb_bd_engine_test.sv
module usb_bd_engine_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_stat_we;
    logic [7:0]  cpu_stat_wdata;
    logic        cpu_cnt_we;
    logic [7:0]  cpu_cnt_wdata;
    logic [7:0]  stat_rd;
    logic [7:0]  cnt_lo_rd;
    logic        tok_valid;
    logic [1:0]  tok_kind;
    logic        tok_odd;
    logic [9:0]  tok_rx_len;
    logic        res_valid;
    logic [2:0]  res_code;
    logic [9:0]  res_len;
    logic        xfer_done;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2;
    localparam logic [2:0] C_ACK = 3'd1, C_NAK = 3'd2, C_STALL = 3'd3, C_IGN = 3'd4;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_bd_engine uut (
        .clk(clk), .rst(rst),
        .cpu_stat_we(cpu_stat_we), .cpu_stat_wdata(cpu_stat_wdata),
        .cpu_cnt_we(cpu_cnt_we), .cpu_cnt_wdata(cpu_cnt_wdata),
        .stat_rd(stat_rd), .cnt_lo_rd(cnt_lo_rd),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_odd(tok_odd),
        .tok_rx_len(tok_rx_len),
        .res_valid(res_valid), .res_code(res_code), .res_len(res_len),
        .xfer_done(xfer_done)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_stat_we = 0; cpu_cnt_we = 0; tok_valid = 0;
        cpu_stat_wdata = 0; cpu_cnt_wdata = 0;
        tok_kind = 0; tok_odd = 0; tok_rx_len = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_stat(logic [7:0] v);
        cpu_stat_we = 1; cpu_stat_wdata = v;
        @(negedge clk);
        cpu_stat_we = 0;
    endtask

    task automatic wr_cnt(logic [7:0] v);
        cpu_cnt_we = 1; cpu_cnt_wdata = v;
        @(negedge clk);
        cpu_cnt_we = 0;
    endtask

    // token presented for one edge; outputs sampled at the following negedge
    task automatic token(logic [1:0] k, logic odd, logic [9:0] len);
        tok_valid = 1; tok_kind = k; tok_odd = odd; tok_rx_len = len;
        @(negedge clk);
        tok_valid = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 stat", stat_rd, 8'h00);
        chk("R1 cnt", cnt_lo_rd, 8'h00);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 done", xfer_done, 0);
    endtask

    task automatic t_cpu_write_and_nak();
        do_reset();
        wr_stat(8'h3D);
        chk("R2 rsv bits read zero", stat_rd, 8'h0D);
        wr_cnt(8'h55);
        chk("R3 count write", cnt_lo_rd, 8'h55);
        token(K_IN, 0, 10'd0);
        chk("R6 nak code", res_code, C_NAK);
        chk("R5 res_valid", res_valid, 1);
        chk("R6 stat unchanged", stat_rd, 8'h0D);
        chk("R6 no done", xfer_done, 0);
    endtask

    task automatic t_lockout();
        do_reset();
        wr_cnt(8'h11);
        wr_stat(8'h80);
        chk("R3 arm", stat_rd, 8'h80);
        wr_stat(8'h0C);
        chk("R4 stat blocked", stat_rd, 8'h80);
        wr_cnt(8'h99);
        chk("R4 cnt blocked", cnt_lo_rd, 8'h11);
    endtask

    task automatic t_stall();
        do_reset();
        wr_cnt(8'h20);
        wr_stat(8'h84);
        token(K_OUT, 0, 10'd7);
        chk("R7 stall code", res_code, C_STALL);
        chk("R7 stat unchanged", stat_rd, 8'h84);
        chk("R7 cnt unchanged", cnt_lo_rd, 8'h20);
        chk("R7 no done", xfer_done, 0);
    endtask

    task automatic t_toggle();
        do_reset();
        wr_stat(8'h88);
        token(K_OUT, 1, 10'h0AA);
        chk("R8 ignore code", res_code, C_IGN);
        chk("R8 stat unchanged", stat_rd, 8'h88);
        chk("R8 cnt unchanged", cnt_lo_rd, 8'h00);
        token(K_OUT, 0, 10'h123);
        chk("R12 ack code", res_code, C_ACK);
        chk("R12 res_len", res_len, 10'h123);
        chk("R13 stat released toggled", stat_rd, 8'h49);
        chk("R12 cnt stored", cnt_lo_rd, 8'h23);
        chk("R13 done high", xfer_done, 1);
        @(negedge clk);
        chk("R13 done one cycle", xfer_done, 0);
    endtask

    task automatic t_check_off();
        do_reset();
        wr_stat(8'h80);
        token(K_OUT, 1, 10'd5);
        chk("R9 ack code", res_code, C_ACK);
        chk("R9 stat", stat_rd, 8'h40);
        chk("R9 cnt", cnt_lo_rd, 8'h05);
    endtask

    task automatic t_setup();
        do_reset();
        wr_stat(8'h88);
        token(K_SETUP, 1, 10'd8);
        chk("R10 ack code", res_code, C_ACK);
        chk("R10 toggle to DATA1", stat_rd, 8'h48);
        chk("R12 setup cnt", cnt_lo_rd, 8'h08);
        wr_stat(8'hC8);
        token(K_SETUP, 0, 10'd8);
        chk("R10 setup keeps DATA1", stat_rd, 8'h48);
    endtask

    task automatic t_in();
        do_reset();
        wr_cnt(8'hFF);
        wr_stat(8'h83);
        token(K_IN, 0, 10'd0);
        chk("R11 ack code", res_code, C_ACK);
        chk("R11 res_len max", res_len, 1023);
        chk("R11 stat", stat_rd, 8'h43);
        chk("R11 cnt unchanged", cnt_lo_rd, 8'hFF);
        wr_stat(8'hC3);
        token(K_IN, 1, 10'd0);
        chk("R13 toggle back to 0", stat_rd, 8'h03);
        chk("R13 done", xfer_done, 1);
    endtask

    initial begin
        rst = 1'b1;
        cpu_stat_we = 0; cpu_cnt_we = 0; tok_valid = 0;
        cpu_stat_wdata = 0; cpu_cnt_wdata = 0;
        tok_kind = 0; tok_odd = 0; tok_rx_len = 0;
        t_reset();
        t_cpu_write_and_nak();
        t_lockout();
        t_stall();
        t_toggle();
        t_check_off();
        t_setup();
        t_in();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule